// File: doc/BRIEF.md
# Paged Management Register Window Bridge

This block sits behind a serial management port and turns its 16-bit accesses into accesses on a 32-bit internal register space. Each management transaction arrives already deframed as a one-cycle request carrying a 5-bit PHY address, a 5-bit register number, a direction and 16 bits of write data. The bridge decodes that pair into an 18-bit word-aligned internal address using a 9-bit page register plus eight banked PHY addresses, and it drives a simple internal bus with address, write data, a write strobe, a read strobe and returned read data.

A 32-bit word is moved as two 16-bit halves. Software writes the high half first, which is only staged, and then the low half, which commits the whole word in one strobe. Reads go the other way. The low-half read performs the single internal read and captures the upper 16 bits, so the high-half read that follows returns data from the same snapshot. The internal bus answers combinationally in the cycle of the strobe. Management read data is returned one cycle after the request with a valid pulse.

Top module: `mdio_page_bridge`

## Requirements
- R1: A write to PHY address 0x18, register 0 loads the page from write data bits [8:0]. A read of that same location returns the page zero-extended to 16 bits.
- R2: For a request at a window PHY address (0x10 to 0x17), bus_addr equals {page, PHY address bits [2:0], register bits [4:1], 2'b00}. The page occupies bus_addr[17:9].
- R3: Whenever bus_we or bus_re is high, bus_addr[1:0] is 00.
- R4: A write to an odd register in a window stores the write data as the staged high half and raises neither bus_we nor bus_re.
- R5: A write to an even register in a window raises bus_we for exactly that request cycle, with bus_wdata = {staged high half, write data}. bus_re stays low.
- R6: A read of an even register in a window raises bus_re in the request cycle. In the next cycle mgmt_rvalid is high and mgmt_rdata holds bus_rdata[15:0].
- R7: A read of an odd register in a window returns bus_rdata[31:16] as captured by the last even-register read, even if the internal data has changed since then. It does not strobe the internal bus.
- R8: A request to a PHY address outside 0x10 to 0x18 causes no bus strobe and changes no state. A read of such an address returns 0xFFFF.
- R9: Reset clears the page, the staged high half and the captured high half to zero, and it clears mgmt_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_req | input | 1 | One-cycle management transaction request |
| mgmt_we | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | PHY address of the transaction |
| mgmt_reg | input | 5 | Register number of the transaction |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data, valid with mgmt_rvalid |
| mgmt_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_addr | output | 18 | Internal word-aligned byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | Internal single-cycle write strobe |
| bus_re | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid in the strobe cycle |

## Verification
The assertions watch, on every cycle, the properties that hold for all traffic. Strobes carry an aligned address and never both fire together. Odd-half writes and out-of-range requests never touch the internal bus, read data valid follows only a read request, and out-of-range reads answer 0xFFFF. Other behaviour needs a known history, so only the bench scenarios can show it: the exact composed address for a given page and window, the pairing of a staged high half with a later low half, and the snapshot property of a high-half read after the internal data has changed. The same holds for the state left zero by a reset in the middle of a run.

// File: rtl/mdio_page_bridge_pkg.sv
package mdio_page_bridge_pkg;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned PAGE_W   = 9;
  localparam int unsigned WIN_BITS = 3;
  localparam int unsigned REG_SEL  = 4;
  localparam int unsigned ADDR_W   = PAGE_W + WIN_BITS + REG_SEL + 2;
  localparam logic [4:0]  PAGE_PHY = 5'h18;
  localparam logic [4:0]  WIN_BASE = 5'h10;
  localparam logic [15:0] IDLE_RD  = 16'hFFFF;

  typedef struct packed {
    logic page_wr;
    logic page_rd;
    logic hi_wr;
    logic lo_wr;
    logic lo_rd;
    logic hi_rd;
  } acc_kind_t;
endpackage

// File: rtl/mdio_win_decode.sv
module mdio_win_decode
  import mdio_page_bridge_pkg::*;
(
  input  logic       req,
  input  logic       we,
  input  logic [4:0] phy,
  input  logic [4:0] regn,
  output acc_kind_t  kind,
  output logic       in_window
);
  logic is_page;
  logic is_win;

  always_comb begin
    is_page   = (phy == PAGE_PHY) && (regn == 5'd0);
    is_win    = (phy[4:WIN_BITS] == WIN_BASE[4:WIN_BITS]);
    in_window = is_win;
    kind.page_wr = req &&  we && is_page;
    kind.page_rd = req && !we && is_page;
    kind.hi_wr   = req &&  we && is_win &&  regn[0];
    kind.lo_wr   = req &&  we && is_win && !regn[0];
    kind.lo_rd   = req && !we && is_win && !regn[0];
    kind.hi_rd   = req && !we && is_win &&  regn[0];
  end
endmodule

// File: rtl/mdio_en_reg.sv
module mdio_en_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_page_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_req,
  input  logic              mgmt_we,
  input  logic [4:0]        mgmt_phy,
  input  logic [4:0]        mgmt_reg,
  input  logic [HALF_W-1:0] mgmt_wdata,
  output logic [HALF_W-1:0] mgmt_rdata,
  output logic              mgmt_rvalid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [2*HALF_W-1:0] bus_rdata
);
  acc_kind_t          kind;
  logic               in_win;
  logic [PAGE_W-1:0]  page_q;
  logic [HALF_W-1:0]  stage_q;
  logic [HALF_W-1:0]  snap_q;
  logic [HALF_W-1:0]  rdata_nxt;
  logic               rvalid_nxt;

  mdio_win_decode dec_i (
    .req       (mgmt_req),
    .we        (mgmt_we),
    .phy       (mgmt_phy),
    .regn      (mgmt_reg),
    .kind      (kind),
    .in_window (in_win)
  );

  mdio_en_reg #(.W(PAGE_W)) page_i (
    .clk (clk), .rst_n (rst_n), .en (kind.page_wr),
    .d (mgmt_wdata[PAGE_W-1:0]), .q (page_q)
  );

  mdio_en_reg #(.W(HALF_W)) stage_i (
    .clk (clk), .rst_n (rst_n), .en (kind.hi_wr),
    .d (mgmt_wdata), .q (stage_q)
  );

  mdio_en_reg #(.W(HALF_W)) snap_i (
    .clk (clk), .rst_n (rst_n), .en (kind.lo_rd),
    .d (bus_rdata[2*HALF_W-1:HALF_W]), .q (snap_q)
  );

  always_comb begin
    bus_addr  = {page_q, mgmt_phy[WIN_BITS-1:0], mgmt_reg[REG_SEL:1], 2'b00};
    bus_wdata = {stage_q, mgmt_wdata};
    bus_we    = kind.lo_wr;
    bus_re    = kind.lo_rd;
  end

  always_comb begin
    rvalid_nxt = mgmt_req && !mgmt_we;
    rdata_nxt  = mgmt_rdata;
    if (rvalid_nxt) begin
      if (kind.lo_rd)        rdata_nxt = bus_rdata[HALF_W-1:0];
      else if (kind.hi_rd)   rdata_nxt = snap_q;
      else if (kind.page_rd) rdata_nxt = {{(HALF_W-PAGE_W){1'b0}}, page_q};
      else                   rdata_nxt = IDLE_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgmt_rdata  <= '0;
      mgmt_rvalid <= 1'b0;
    end else begin
      mgmt_rdata  <= rdata_nxt;
      mgmt_rvalid <= rvalid_nxt;
    end
  end

  logic unused_win;
  assign unused_win = in_win;
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk
  import mdio_page_bridge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mgmt_req,
  input logic              mgmt_we,
  input logic [4:0]        mgmt_phy,
  input logic [4:0]        mgmt_reg,
  input logic [HALF_W-1:0] mgmt_rdata,
  input logic              mgmt_rvalid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re
);
  logic oob;
  assign oob = (mgmt_phy < 5'h10) || (mgmt_phy > 5'h18);

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) |-> (bus_addr[1:0] == 2'b00));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R4
  hi_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_we && mgmt_reg[0]) |-> (!bus_we && !bus_re));

  // R6
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rvalid |-> $past(mgmt_req && !mgmt_we));

  // R8
  oob_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && oob) |-> (!bus_we && !bus_re));

  // R8
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !mgmt_we && oob) |=> (mgmt_rvalid && mgmt_rdata == 16'hFFFF));
endmodule

bind mdio_page_bridge mdio_page_bridge_chk chk_i (
  .clk (clk), .rst_n (rst_n), .mgmt_req (mgmt_req), .mgmt_we (mgmt_we),
  .mgmt_phy (mgmt_phy), .mgmt_reg (mgmt_reg), .mgmt_rdata (mgmt_rdata),
  .mgmt_rvalid (mgmt_rvalid), .bus_addr (bus_addr), .bus_we (bus_we),
  .bus_re (bus_re)
);

// File: tb/mdio_page_bridge_tb_top.sv
module mdio_page_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mgmt_req, mgmt_we;
  logic [4:0]  mgmt_phy, mgmt_reg;
  logic [15:0] mgmt_wdata, mgmt_rdata;
  logic        mgmt_rvalid;
  logic [17:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_we, bus_re;
  logic [31:0] salt;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [8:0]  cur_page;

  always #5 clk = ~clk;

  // register-file stand-in: value depends on address and a changeable salt
  assign bus_rdata = {14'd0, bus_addr} ^ salt;

  mdio_page_bridge dut_i (
    .clk (clk), .rst_n (rst_n), .mgmt_req (mgmt_req), .mgmt_we (mgmt_we),
    .mgmt_phy (mgmt_phy), .mgmt_reg (mgmt_reg), .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata), .mgmt_rvalid (mgmt_rvalid), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_we (bus_we), .bus_re (bus_re),
    .bus_rdata (bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_addr(input logic [8:0] pg,
                                           input logic [4:0] phy,
                                           input logic [4:0] rg);
    return {pg, phy[2:0], rg[4:1], 2'b00};
  endfunction

  // write: drive at negedge, check strobes mid-cycle, release at next negedge
  task automatic mwrite(input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, output logic we_o,
                        output logic re_o, output logic [31:0] wd_o,
                        output logic [17:0] a_o);
    @(negedge clk);
    mgmt_req = 1'b1; mgmt_we = 1'b1; mgmt_phy = phy; mgmt_reg = rg;
    mgmt_wdata = d;
    #1;
    we_o = bus_we; re_o = bus_re; wd_o = bus_wdata; a_o = bus_addr;
    @(negedge clk);
    mgmt_req = 1'b0; mgmt_we = 1'b0;
    #1;
    chk(!bus_we, "R5 strobe single cycle", {31'd0, bus_we}, 32'd0);
  endtask

  task automatic mread(input logic [4:0] phy, input logic [4:0] rg,
                       output logic [15:0] d_o, output logic re_o,
                       output logic [17:0] a_o);
    @(negedge clk);
    mgmt_req = 1'b1; mgmt_we = 1'b0; mgmt_phy = phy; mgmt_reg = rg;
    #1;
    re_o = bus_re; a_o = bus_addr;
    @(negedge clk);
    mgmt_req = 1'b0;
    chk(mgmt_rvalid, "R6 rvalid after read", {31'd0, mgmt_rvalid}, 32'd1);
    d_o = mgmt_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_page = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!mgmt_rvalid, "R9 rvalid clear", {31'd0, mgmt_rvalid}, 32'd0);
  endtask

  task automatic t_page();
    logic we, re; logic [31:0] wd; logic [17:0] a; logic [15:0] d;
    mwrite(5'h18, 5'd0, 16'hFF5A, we, re, wd, a);
    cur_page = 9'h15A;
    chk(!we && !re, "R1 page write no strobe", {30'd0, we, re}, 32'd0);
    mread(5'h18, 5'd0, d, re, a);
    chk(d == 16'h015A, "R1 page readback", {16'd0, d}, 32'h015A);
  endtask

  task automatic t_write_pair(input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] hi, input logic [15:0] lo);
    logic we, re; logic [31:0] wd; logic [17:0] a;
    mwrite(phy, rg | 5'd1, hi, we, re, wd, a);
    chk(!we && !re, "R4 high half staged only", {30'd0, we, re}, 32'd0);
    mwrite(phy, rg & 5'h1E, lo, we, re, wd, a);
    chk(we && !re, "R5 commit strobe", {30'd0, we, re}, 32'd2);
    chk(wd == {hi, lo}, "R5 committed word", wd, {hi, lo});
    chk(a == exp_addr(cur_page, phy, rg), "R2 write address", {14'd0, a},
        {14'd0, exp_addr(cur_page, phy, rg)});
    chk(a[1:0] == 2'b00, "R3 aligned", {30'd0, a[1:0]}, 32'd0);
  endtask

  task automatic t_read_snapshot(input logic [4:0] phy, input logic [4:0] rg);
    logic re; logic [17:0] a; logic [15:0] d; logic [31:0] word;
    salt = 32'hA5C3_0F0F;
    word = {14'd0, exp_addr(cur_page, phy, rg & 5'h1E)} ^ salt;
    mread(phy, rg & 5'h1E, d, re, a);
    chk(re, "R6 low read strobe", {31'd0, re}, 32'd1);
    chk(d == word[15:0], "R6 low half data", {16'd0, d}, {16'd0, word[15:0]});
    chk(a == exp_addr(cur_page, phy, rg), "R2 read address", {14'd0, a},
        {14'd0, exp_addr(cur_page, phy, rg)});
    salt = 32'h1234_5678;
    mread(phy, rg | 5'd1, d, re, a);
    chk(!re, "R7 high read no strobe", {31'd0, re}, 32'd0);
    chk(d == word[31:16], "R7 snapshot high half", {16'd0, d},
        {16'd0, word[31:16]});
  endtask

  task automatic t_oob();
    logic we, re; logic [31:0] wd; logic [17:0] a; logic [15:0] d;
    mwrite(5'h0F, 5'd0, 16'h0077, we, re, wd, a);
    chk(!we && !re, "R8 oob write no strobe", {30'd0, we, re}, 32'd0);
    mwrite(5'h19, 5'd0, 16'h0033, we, re, wd, a);
    chk(!we && !re, "R8 oob write2 no strobe", {30'd0, we, re}, 32'd0);
    mread(5'h1F, 5'd3, d, re, a);
    chk(d == 16'hFFFF, "R8 oob read", {16'd0, d}, 32'hFFFF);
    mread(5'h02, 5'd0, d, re, a);
    chk(d == 16'hFFFF && !re, "R8 oob read low", {15'd0, re, d}, 32'hFFFF);
    mread(5'h18, 5'd0, d, re, a);
    chk(d == {7'd0, cur_page}, "R8 page untouched", {16'd0, d},
        {23'd0, cur_page});
  endtask

  task automatic t_reset_clear();
    logic we, re; logic [31:0] wd; logic [17:0] a; logic [15:0] d;
    mwrite(5'h11, 5'd1, 16'hBEEF, we, re, wd, a);
    do_reset();
    mread(5'h18, 5'd0, d, re, a);
    chk(d == 16'h0000, "R9 page cleared", {16'd0, d}, 32'd0);
    mread(5'h13, 5'd9, d, re, a);
    chk(d == 16'h0000, "R9 snapshot cleared", {16'd0, d}, 32'd0);
    mwrite(5'h12, 5'd4, 16'h00C1, we, re, wd, a);
    chk(wd == 32'h0000_00C1, "R9 stage cleared", wd, 32'h0000_00C1);
    chk(a == exp_addr(9'd0, 5'h12, 5'd4), "R9 page zero in addr", {14'd0, a},
        {14'd0, exp_addr(9'd0, 5'h12, 5'd4)});
  endtask

  initial begin
    rst_n = 1'b0; mgmt_req = 1'b0; mgmt_we = 1'b0; mgmt_phy = '0;
    mgmt_reg = '0; mgmt_wdata = '0; salt = '0; cur_page = '0;
    t_reset();
    t_page();
    t_write_pair(5'h10, 5'd0, 16'h1122, 16'h3344);
    t_write_pair(5'h17, 5'd30, 16'hDEAD, 16'hBEEF);
    t_write_pair(5'h13, 5'd12, 16'h0001, 16'hFFFF);
    t_read_snapshot(5'h15, 5'd6);
    t_read_snapshot(5'h17, 5'd31);
    t_oob();
    t_reset_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule